// File: doc/BRIEF.md
# Command-Driven Eight-Channel DAC Update Sequencer

This block sits at the end of a byte stream and drives a bank of parallel-bus digital-to-analog converters. Bytes arrive one per write-enable cycle and are packed, least significant byte first, into 32-bit words. The two top bits of each word tell the block what the word is. It can be a session setup, which carries a channel enable mask and a rate divider. It can be a disconnect, which releases the sender with a one-cycle done pulse. Otherwise it is a sample for one channel.

Each channel holds one pending sample, and a newer sample replaces an older one. A free-running rate timer produces an update tick every `BASE_DIV × max(ratio,1)` clock cycles. That is 500 cycles for a 200 kHz base rate at a 100 MHz clock. On each tick the block walks the channels that hold a new sample, from lowest index to highest. For each one it drives the value on the shared data bus and pulls that channel's chip select low for a fixed number of cycles. It then pulses a single common load strobe so that all converter outputs change together. The block raises full toward the sender for the whole sequence, so no incoming byte is lost.

Top module: `dac_seq`

## Requirements
- R1: Accepted bytes are packed into 32-bit words with the first byte as bits 7:0 and the fourth as bits 31:24. A byte is taken only in a cycle where `in_we` is high and `in_full` is low.
- R2: A word with bit 31 set starts a session. Its bits 15:8 are the rate ratio and bits 7:0 are the enable mask (bit X enables channel X). Starting a session discards all pending samples, restarts the rate timer, and drives `dac_refen_n` low.
- R3: While a session is active, consecutive load pulses that each follow new data are exactly `500 × max(ratio,1)` clock cycles apart, so a ratio of 0 acts like 1.
- R4: A word with bits 31 and 30 clear is a sample. If bits 23:16 have exactly one bit set and that bit names an enabled channel, bits 15:0 become that channel's pending sample. A later sample to the same channel replaces the earlier one.
- R5: A sample is dropped if its channel field has no bit set or more than one bit set, if it names a disabled channel, or if it arrives outside a session.
- R6: On an update tick, every channel holding a new sample is written in ascending channel order. For each write, exactly one chip select is low for exactly `CS_HOLD` (2) cycles, with the sample on `dac_data` and `dac_rnw` low. A channel without a new sample is not written.
- R7: After the last chip select of an update, `dac_ldac_n` goes low for one cycle, and never while any chip select is low. An update with nothing pending gives no load pulse.
- R8: A word with bit 31 clear and bit 30 set gives a one-cycle `in_done` pulse and ends the session: `dac_refen_n` goes high and no further updates occur. Session-start and sample words give no done pulse.
- R9: `in_full` is high during every cycle of a write sequence, including the load pulse, and low when the sequencer is idle.
- R10: Out of reset, all chip selects and the load strobe are high, `in_full` and `in_done` are low, and `dac_refen_n` is high. `dac_rst_n` is low while reset is applied and high afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_we | input | 1 | Byte write enable from the sender |
| in_byte | input | 8 | Byte data |
| in_full | output | 1 | Sender must hold the current byte |
| in_done | output | 1 | One-cycle pulse on disconnect |
| dac_rnw | output | 1 | Read-not-write, low while writing |
| dac_cs_n | output | 8 | Per-channel chip selects, active low |
| dac_ldac_n | output | 1 | Common load strobe, active low |
| dac_rst_n | output | 1 | Converter reset, active low |
| dac_refen_n | output | 1 | Internal reference enable, active low |
| dac_data | output | 16 | Sample value for the selected channel |

## Verification
The bench targets malformed channel fields: an empty field, a field with two bits set, and a field naming a disabled channel. A design that failed to drop any of these would produce a write on some chip select. It sends several samples out of channel order within one period, with a repeated channel. Wrong ordering, or keeping the stale value instead of the latest one, shows in the logged write sequence. The gap between load pulses is measured for ratios 0, 1 and 3. A divider that treated 0 literally, or that was off by one, would shift that gap. Disconnect is checked for its done pulse and for stopping later updates. Samples sent before any session are checked to leave no trace.

// File: rtl/dac_seq_pkg.sv
package dac_seq_pkg;
   localparam int WORD_W   = 32;
   localparam int BYTE_W   = 8;
   localparam int SEL_LO   = 16;
   localparam int SEL_W    = 8;
   localparam int RATIO_LO = 8;
   localparam int BIT_INIT = 31;
   localparam int BIT_DISC = 30;

   typedef enum logic [1:0] {WR_IDLE, WR_CHAN, WR_LOAD} wr_state_e;

   function automatic logic [2:0] lowest8(input logic [7:0] m);
      logic [2:0] r;
      r = 3'd0;
      for (int i = 7; i >= 0; i--)
         if (m[i]) r = 3'(i);
      return r;
   endfunction
endpackage

// File: rtl/dac_seq_asm.sv
module dac_seq_asm
   import dac_seq_pkg::*;
#(
   parameter int BYTES = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [BYTE_W-1:0] byte_in,
   input  logic              full,
   output logic              word_vld,
   output logic [WORD_W-1:0] word
);
   localparam int CNT_W = $clog2(BYTES);

   logic [WORD_W-1:0] shreg;
   logic [CNT_W-1:0]  cnt;
   logic [WORD_W-1:0] shifted;

   assign shifted = {byte_in, shreg[WORD_W-1:BYTE_W]};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shreg    <= '0;
         cnt      <= '0;
         word_vld <= 1'b0;
         word     <= '0;
      end else begin
         word_vld <= 1'b0;
         if (we && !full) begin
            shreg <= shifted;
            if (cnt == CNT_W'(BYTES - 1)) begin
               cnt      <= '0;
               word     <= shifted;
               word_vld <= 1'b1;
            end else begin
               cnt <= cnt + 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/dac_seq_cmd.sv
module dac_seq_cmd
   import dac_seq_pkg::*;
#(
   parameter int NUM_CH  = 8,
   parameter int DATA_W  = 16,
   parameter int RATIO_W = 8
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          word_vld,
   input  logic [WORD_W-1:0]             word,
   input  logic [NUM_CH-1:0]             clr,
   output logic                          active,
   output logic [RATIO_W-1:0]            ratio,
   output logic                          restart,
   output logic [NUM_CH-1:0]             pend_flag,
   output logic [NUM_CH-1:0][DATA_W-1:0] pend_data,
   output logic                          done
);
   logic              is_init, is_disc, is_samp, samp_hit;
   logic [SEL_W-1:0]  sel;
   logic [NUM_CH-1:0] en_mask;

   assign sel      = word[SEL_LO +: SEL_W];
   assign is_init  = word_vld && word[BIT_INIT];
   assign is_disc  = word_vld && !word[BIT_INIT] && word[BIT_DISC];
   assign is_samp  = word_vld && !word[BIT_INIT] && !word[BIT_DISC];
   assign samp_hit = is_samp && active && $onehot(sel) && |(sel[NUM_CH-1:0] & en_mask);
   assign restart  = is_init;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active  <= 1'b0;
         ratio   <= '0;
         en_mask <= '0;
         done    <= 1'b0;
      end else begin
         done <= is_disc;
         if (is_init) begin
            active  <= 1'b1;
            ratio   <= word[RATIO_LO +: RATIO_W];
            en_mask <= word[NUM_CH-1:0];
         end else if (is_disc) begin
            active <= 1'b0;
         end
      end
   end

   for (genvar c = 0; c < NUM_CH; c++) begin : g_slot
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            pend_flag[c] <= 1'b0;
            pend_data[c] <= '0;
         end else if (is_init) begin
            pend_flag[c] <= 1'b0;
         end else if (samp_hit && sel[c]) begin
            pend_flag[c] <= 1'b1;
            pend_data[c] <= word[DATA_W-1:0];
         end else if (clr[c]) begin
            pend_flag[c] <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/dac_seq_tick.sv
module dac_seq_tick #(
   parameter int BASE_DIV = 500,
   parameter int RATIO_W  = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               active,
   input  logic               restart,
   input  logic [RATIO_W-1:0] ratio,
   output logic               tick
);
   localparam int MAX_PER = BASE_DIV * ((1 << RATIO_W) - 1);
   localparam int CNT_W   = $clog2(MAX_PER + 1);

   logic [CNT_W-1:0]   cnt, lim;
   logic [RATIO_W-1:0] eff;

   assign eff = (ratio == '0) ? RATIO_W'(1) : ratio;
   assign lim = CNT_W'(BASE_DIV) * CNT_W'(eff);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt  <= '0;
         tick <= 1'b0;
      end else begin
         tick <= 1'b0;
         if (restart || !active) begin
            cnt <= '0;
         end else if (cnt == lim - 1'b1) begin
            cnt  <= '0;
            tick <= 1'b1;
         end else begin
            cnt <= cnt + 1'b1;
         end
      end
   end
endmodule

// File: rtl/dac_seq_wr.sv
module dac_seq_wr
   import dac_seq_pkg::*;
#(
   parameter int NUM_CH  = 8,
   parameter int DATA_W  = 16,
   parameter int CS_HOLD = 2
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          tick,
   input  logic [NUM_CH-1:0]             pend_flag,
   input  logic [NUM_CH-1:0][DATA_W-1:0] pend_data,
   output logic [NUM_CH-1:0]             clr,
   output logic [NUM_CH-1:0]             cs_n,
   output logic [DATA_W-1:0]             data,
   output logic                          ldac_n,
   output logic                          rnw,
   output logic                          busy
);
   localparam int CH_W = $clog2(NUM_CH);
   localparam int HC_W = $clog2(CS_HOLD + 1);

   wr_state_e         state;
   logic [NUM_CH-1:0] rem, rem_after, pick;
   logic [CH_W-1:0]   cur, pick_idx;
   logic [HC_W-1:0]   hcnt;
   logic              hold_end, start;

   assign rem_after = rem & ~(NUM_CH'(1) << cur);
   assign pick      = (state == WR_IDLE) ? pend_flag : rem_after;
   assign pick_idx  = CH_W'(lowest8(8'(pick)));
   assign hold_end  = (state == WR_CHAN) && (hcnt == HC_W'(CS_HOLD - 1));
   assign start     = (state == WR_IDLE) && tick && |pend_flag;

   always_comb begin
      clr = '0;
      if (start || (hold_end && |rem_after))
         clr = NUM_CH'(1) << pick_idx;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= WR_IDLE;
         rem    <= '0;
         cur    <= '0;
         hcnt   <= '0;
         cs_n   <= '1;
         data   <= '0;
         ldac_n <= 1'b1;
      end else begin
         case (state)
            WR_IDLE: if (start) begin
               rem   <= pend_flag;
               cur   <= pick_idx;
               hcnt  <= '0;
               cs_n  <= ~(NUM_CH'(1) << pick_idx);
               data  <= pend_data[pick_idx];
               state <= WR_CHAN;
            end
            WR_CHAN: if (hold_end) begin
               if (|rem_after) begin
                  rem  <= rem_after;
                  cur  <= pick_idx;
                  hcnt <= '0;
                  cs_n <= ~(NUM_CH'(1) << pick_idx);
                  data <= pend_data[pick_idx];
               end else begin
                  cs_n   <= '1;
                  ldac_n <= 1'b0;
                  state  <= WR_LOAD;
               end
            end else begin
               hcnt <= hcnt + 1'b1;
            end
            default: begin
               ldac_n <= 1'b1;
               state  <= WR_IDLE;
            end
         endcase
      end
   end

   assign rnw  = &cs_n;
   assign busy = (state != WR_IDLE);
endmodule

// File: rtl/dac_seq.sv
module dac_seq
   import dac_seq_pkg::*;
#(
   parameter int NUM_CH   = 8,
   parameter int DATA_W   = 16,
   parameter int RATIO_W  = 8,
   parameter int BASE_DIV = 500,
   parameter int CS_HOLD  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_we,
   input  logic [7:0]        in_byte,
   output logic              in_full,
   output logic              in_done,
   output logic              dac_rnw,
   output logic [NUM_CH-1:0] dac_cs_n,
   output logic              dac_ldac_n,
   output logic              dac_rst_n,
   output logic              dac_refen_n,
   output logic [DATA_W-1:0] dac_data
);
   if (NUM_CH < 2 || NUM_CH > SEL_W) begin : g_bad_ch
      $error("dac_seq: NUM_CH must lie in 2..8");
   end
   if (DATA_W < 1 || DATA_W > SEL_LO) begin : g_bad_w
      $error("dac_seq: DATA_W must lie in 1..16");
   end
   if (RATIO_W < 1 || RATIO_W > 8) begin : g_bad_r
      $error("dac_seq: RATIO_W must lie in 1..8");
   end
   if (CS_HOLD < 2 || BASE_DIV < 16) begin : g_bad_t
      $error("dac_seq: CS_HOLD >= 2 and BASE_DIV >= 16 required");
   end

   logic                          word_vld, active, restart, tick, busy;
   logic [WORD_W-1:0]             word;
   logic [RATIO_W-1:0]            ratio;
   logic [NUM_CH-1:0]             pend_flag, clr;
   logic [NUM_CH-1:0][DATA_W-1:0] pend_data;
   logic                          rst_q;

   dac_seq_asm #(.BYTES(WORD_W / BYTE_W)) u_asm (
      .clk(clk), .rst_n(rst_n), .we(in_we), .byte_in(in_byte), .full(busy),
      .word_vld(word_vld), .word(word));

   dac_seq_cmd #(.NUM_CH(NUM_CH), .DATA_W(DATA_W), .RATIO_W(RATIO_W)) u_cmd (
      .clk(clk), .rst_n(rst_n), .word_vld(word_vld), .word(word), .clr(clr),
      .active(active), .ratio(ratio), .restart(restart), .pend_flag(pend_flag),
      .pend_data(pend_data), .done(in_done));

   dac_seq_tick #(.BASE_DIV(BASE_DIV), .RATIO_W(RATIO_W)) u_tick (
      .clk(clk), .rst_n(rst_n), .active(active), .restart(restart),
      .ratio(ratio), .tick(tick));

   dac_seq_wr #(.NUM_CH(NUM_CH), .DATA_W(DATA_W), .CS_HOLD(CS_HOLD)) u_wr (
      .clk(clk), .rst_n(rst_n), .tick(tick), .pend_flag(pend_flag),
      .pend_data(pend_data), .clr(clr), .cs_n(dac_cs_n), .data(dac_data),
      .ldac_n(dac_ldac_n), .rnw(dac_rnw), .busy(busy));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rst_q <= 1'b0;
      else        rst_q <= 1'b1;
   end

   assign dac_rst_n   = rst_q;
   assign dac_refen_n = !active;
   assign in_full     = busy;
endmodule

// File: rtl/dac_seq_chk.sv
module dac_seq_chk #(
   parameter int NUM_CH = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              in_full,
   input logic              in_done,
   input logic              dac_rnw,
   input logic [NUM_CH-1:0] dac_cs_n,
   input logic              dac_ldac_n,
   input logic              dac_refen_n
);
   assert_cs_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(~dac_cs_n));

   assert_rnw_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (dac_cs_n != '1) |-> !dac_rnw);

   assert_cs_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (dac_cs_n != '1 && dac_cs_n != $past(dac_cs_n)) |=> (dac_cs_n == $past(dac_cs_n)));

   assert_load_apart_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !dac_ldac_n |-> (dac_cs_n == '1));

   assert_load_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !dac_ldac_n |=> dac_ldac_n);

   assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
      in_done |=> !in_done);

   assert_done_ends_R8: assert property (@(posedge clk) disable iff (!rst_n)
      in_done |-> dac_refen_n);

   assert_full_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
      ((dac_cs_n != '1) || !dac_ldac_n) |-> in_full);
endmodule

bind dac_seq dac_seq_chk #(.NUM_CH(NUM_CH)) u_chk (
   .clk(clk), .rst_n(rst_n), .in_full(in_full), .in_done(in_done),
   .dac_rnw(dac_rnw), .dac_cs_n(dac_cs_n), .dac_ldac_n(dac_ldac_n),
   .dac_refen_n(dac_refen_n));

// File: tb/dac_seq_test.sv
module dac_seq_test;
   localparam int CLK_PERIOD = 10;
   localparam int PER        = 500;

   typedef struct packed {
      logic [7:0]  en;
      logic [31:0] w;
      logic        wr;
      logic [2:0]  ch;
   } vec_t;

   localparam vec_t VEC [6] = '{
      '{en: 8'hFF, w: 32'h0001_1234, wr: 1'b1, ch: 3'd0},
      '{en: 8'hFF, w: 32'h0080_BEEF, wr: 1'b1, ch: 3'd7},
      '{en: 8'h0F, w: 32'h0010_5555, wr: 1'b0, ch: 3'd4},
      '{en: 8'hFF, w: 32'h0003_7777, wr: 1'b0, ch: 3'd0},
      '{en: 8'hFF, w: 32'h0000_1111, wr: 1'b0, ch: 3'd0},
      '{en: 8'h20, w: 32'h0020_A5A5, wr: 1'b1, ch: 3'd5}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_we = 1'b0;
   logic [7:0]  in_byte = '0;
   logic        in_full, in_done, dac_rnw, dac_ldac_n, dac_rst_n, dac_refen_n;
   logic [7:0]  dac_cs_n;
   logic [15:0] dac_data;

   int n_chk = 0, n_fail = 0;
   int cyc = 0, n_wr = 0, ld_cnt = 0, ld_time = 0, done_cnt = 0;
   int full_bad = 0, ld_bad = 0, full_seen = 0;
   int wr_ch [64];
   int wr_data [64];
   int wr_len [64];
   logic [7:0] prev_cs = 8'hFF;
   logic       prev_ld = 1'b1;

   dac_seq uut (
      .clk(clk), .rst_n(rst_n), .in_we(in_we), .in_byte(in_byte),
      .in_full(in_full), .in_done(in_done), .dac_rnw(dac_rnw),
      .dac_cs_n(dac_cs_n), .dac_ldac_n(dac_ldac_n), .dac_rst_n(dac_rst_n),
      .dac_refen_n(dac_refen_n), .dac_data(dac_data));

   always #(CLK_PERIOD / 2) clk = ~clk;

   always @(negedge clk) begin
      cyc++;
      if (rst_n) begin
         if (dac_cs_n != 8'hFF) begin
            if (dac_cs_n == prev_cs) begin
               if (n_wr > 0) wr_len[n_wr-1]++;
            end else if (n_wr < 64) begin
               for (int i = 0; i < 8; i++)
                  if (!dac_cs_n[i]) wr_ch[n_wr] = i;
               wr_data[n_wr] = int'(dac_data);
               wr_len[n_wr]  = 1;
               n_wr++;
            end
            if (!in_full) full_bad++;
         end
         if (in_full) full_seen++;
         if (!dac_ldac_n && prev_ld) begin
            ld_cnt++;
            ld_time = cyc;
            if (dac_cs_n != 8'hFF || !in_full) ld_bad++;
         end
         if (in_done) done_cnt++;
      end
      prev_cs = dac_cs_n;
      prev_ld = dac_ldac_n;
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic finish_run;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   endtask

   task automatic send_word(input logic [31:0] w);
      for (int b = 0; b < 4; b++) begin
         @(negedge clk);
         while (in_full) @(negedge clk);
         in_we   = 1'b1;
         in_byte = w[8*b +: 8];
         @(negedge clk);
         in_we = 1'b0;
      end
   endtask

   task automatic wait_cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wait_load;
      int c0;
      c0 = ld_cnt;
      while (ld_cnt == c0) @(negedge clk);
   endtask

   task automatic rate_test(input int ratio, input string req);
      int t1, diff, exp;
      send_word(32'h8000_0001 | (ratio << 8));
      send_word(32'h0001_0101);
      wait_load();
      t1 = ld_time;
      send_word(32'h0001_0202);
      wait_load();
      diff = ld_time - t1;
      exp  = PER * ((ratio == 0) ? 1 : ratio);
      chk(diff == exp, req, diff, exp);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_fail++;
      n_chk++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      finish_run();
   end

   initial begin
      int base, c0;
      wait_cyc(3);
      // R10: state while reset is applied
      chk(dac_rst_n == 1'b0, "R10 dac_rst_n in reset", dac_rst_n, 0);
      chk(dac_cs_n == 8'hFF && dac_ldac_n, "R10 cs/load in reset", dac_cs_n, 8'hFF);
      rst_n = 1'b1;
      wait_cyc(3);
      chk(dac_rst_n == 1'b1, "R10 dac_rst_n after reset", dac_rst_n, 1);
      chk(!in_full && !in_done, "R10 full/done idle", {in_full, in_done}, 0);
      chk(dac_refen_n == 1'b1, "R10 refen idle", dac_refen_n, 1);

      // R5: samples before any session are dropped
      base = n_wr;
      send_word(32'h0001_4321);
      wait_cyc(1100);
      chk(n_wr == base, "R5 sample outside session", n_wr - base, 0);

      // Vector table: R1 R2 R4 R5 R6
      for (int v = 0; v < 6; v++) begin
         base = n_wr;
         send_word(32'h8000_0000 | VEC[v].en);
         send_word(VEC[v].w);
         wait_cyc(1100);
         chk(n_wr - base == (VEC[v].wr ? 1 : 0), "R5 R4 write count", n_wr - base, VEC[v].wr);
         if (VEC[v].wr && n_wr > base) begin
            chk(wr_ch[base] == VEC[v].ch, "R6 channel", wr_ch[base], VEC[v].ch);
            chk(wr_data[base] == int'(VEC[v].w[15:0]), "R1 sample value", wr_data[base], VEC[v].w[15:0]);
            chk(wr_len[base] == 2, "R6 cs hold", wr_len[base], 2);
         end
      end
      chk(dac_refen_n == 1'b0, "R2 refen in session", dac_refen_n, 0);

      // R4 R6 R7: ordering, replacement, single load
      send_word(32'h8000_00FF);
      base = n_wr;
      c0   = ld_cnt;
      send_word(32'h0040_6666);
      send_word(32'h0002_1111);
      send_word(32'h0008_3333);
      send_word(32'h0002_2222);
      wait_cyc(700);
      chk(n_wr - base == 3, "R6 writes in update", n_wr - base, 3);
      chk(wr_ch[base] == 1 && wr_ch[base+1] == 3 && wr_ch[base+2] == 6,
          "R6 ascending order", wr_ch[base] * 256 + wr_ch[base+1] * 16 + wr_ch[base+2], 'h136);
      chk(wr_data[base] == 'h2222, "R4 latest sample kept", wr_data[base], 'h2222);
      chk(wr_data[base+2] == 'h6666, "R6 data ch6", wr_data[base+2], 'h6666);
      chk(ld_cnt - c0 == 1, "R7 one load pulse", ld_cnt - c0, 1);
      c0 = ld_cnt;
      wait_cyc(600);
      chk(ld_cnt == c0, "R7 no load when nothing pending", ld_cnt - c0, 0);
      chk(ld_bad == 0, "R7 load apart from cs", ld_bad, 0);

      // R2: session start discards pending samples
      base = n_wr;
      send_word(32'h8000_00FF);
      send_word(32'h0004_7070);
      send_word(32'h8000_00FF);
      wait_cyc(1100);
      chk(n_wr == base, "R2 init clears pending", n_wr - base, 0);

      // R3: update rate
      rate_test(0, "R3 ratio 0");
      rate_test(1, "R3 ratio 1");
      rate_test(3, "R3 ratio 3");

      // R9: full during sequences
      chk(full_bad == 0, "R9 full during write", full_bad, 0);
      chk(full_seen > 0, "R9 full raised", full_seen, 1);
      wait_cyc(5);
      chk(!in_full, "R9 full low when idle", in_full, 0);

      // R8: disconnect
      chk(done_cnt == 0, "R8 no done from init/sample", done_cnt, 0);
      send_word(32'h4000_0000);
      wait_cyc(3);
      chk(done_cnt == 1, "R8 done pulse", done_cnt, 1);
      chk(dac_refen_n == 1'b1, "R8 refen released", dac_refen_n, 1);
      base = n_wr;
      send_word(32'h0001_5A5A);
      wait_cyc(1100);
      chk(n_wr == base, "R8 no update after disconnect", n_wr - base, 0);

      finish_run();
   end
endmodule